// File: doc/BRIEF.md
# Power Gating Domain Sequencer

This block sequences the sleep and wake of one switched logic domain whose supply is cut by distributed header or footer switches. A single level input asks for sleep. On a sleep request the sequencer first clamps the domain's outputs through an isolation enable and then, one cycle later, turns both switch groups off. On a wake request it turns on a small group of switches first. Starting with a few switches limits inrush current. It waits for that group's enable to come back out of the end of its daisy chain, then turns on the bulk group and waits for that chain's return. Only then does it release isolation and report the domain ready.

Each chain return is resynchronized through a configurable number of flip-flop stages before the state machine sees it. While the sequencer waits for a return, a counter measures the wait against a limit given on an input. If the limit is passed, an error flag goes high and the sequencer stays in its state until the return arrives.

The state machine has five states. ASLEEP drives isolation on and both groups off. WAKE_SMALL drives isolation on and the small group on. WAKE_BULK drives isolation on and both groups on. READY drives isolation off, both groups on and ready high. CLAMP drives isolation on and both groups on. There are five transitions. ASLEEP goes to WAKE_SMALL when sleep is not requested and both resynchronized returns are low. WAKE_SMALL goes to WAKE_BULK on the small return. WAKE_BULK goes to READY on the bulk return. READY goes to CLAMP on a sleep request. CLAMP always goes to ASLEEP after one cycle.

Top module: `pwr_gate_seq`

## Requirements
- R1: While reset is low and after it is released, iso_en is 1, small_en, bulk_en, dom_ready and ret_timeout are 0.
- R2: In ASLEEP with sleep_req low and both resynchronized returns low, the next clock edge turns small_en on while iso_en stays 1 and bulk_en stays 0.
- R3: A return input is seen by the state machine ACK_SYNC edges after it is first sampled. While either resynchronized return is high, ASLEEP does not start a wake. After the last return falls at the edge that samples it as low, small_en rises ACK_SYNC edges later.
- R4: bulk_en rises at the edge ACK_SYNC edges after small_ret is first sampled high in WAKE_SMALL, and not earlier.
- R5: iso_en falls and dom_ready rises together at the edge ACK_SYNC edges after bulk_ret is first sampled high in WAKE_BULK. In READY, iso_en is 0 and small_en, bulk_en and dom_ready are 1.
- R6: sleep_req high in READY makes the next edge raise iso_en and drop dom_ready with both groups still on. The edge after that turns both groups off.
- R7: sleep_req raised during WAKE_SMALL or WAKE_BULK does not stop the wake. The domain passes through READY for exactly one cycle and then enters CLAMP.
- R8: CLAMP always moves to ASLEEP, even if sleep_req has fallen again.
- R9: If a group's enable turned on at edge E and its return has not been seen, ret_timeout is 1 from edge E+tmo_limit+1 onward. While ret_timeout is 1, all enables and iso_en keep their values.
- R10: When the awaited return arrives, ret_timeout clears at the same edge at which the sequencer advances. The count restarts from zero for the next group.
- R11: In ASLEEP, sleep_req high keeps the domain asleep with both groups off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | 1 requests sleep, 0 requests the domain awake |
| tmo_limit | input | TMO_W | Return wait limit in cycles |
| small_ret | input | 1 | Enable returned from the end of the small switch chain |
| bulk_ret | input | 1 | Enable returned from the end of the bulk switch chain |
| iso_en | output | 1 | Isolation clamp enable for the domain outputs |
| small_en | output | 1 | Enable into the small switch chain |
| bulk_en | output | 1 | Enable into the bulk switch chain |
| dom_ready | output | 1 | Domain powered and unclamped |
| ret_timeout | output | 1 | Chain return overdue |

## Verification
The bench sweeps every pairing of timeout limit 0 to 3 with return delays 0 to 4 for both groups. It checks the exact cycle at which each enable rises and the exact cycle at which the error flag appears or stays away. An off-by-one in the resynchronizer depth or the timeout counter would move one of these edges. A design that let a return race past the counter would also fail. Sleep requests arriving mid-wake and wake requests arriving during CLAMP are driven to catch a design that aborts a half-finished sequence or skips the one-cycle clamp. A dedicated case holds a stale return high in ASLEEP to catch a design that would start a wake and take the old return as a fresh acknowledgement.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    // Sequencer states; encoding is free, nothing outside decodes it.
    typedef enum logic [2:0] {
        PGS_ASLEEP     = 3'd0,
        PGS_WAKE_SMALL = 3'd1,
        PGS_WAKE_BULK  = 3'd2,
        PGS_READY      = 3'd3,
        PGS_CLAMP      = 3'd4
    } pgs_state_e;

    // Drive bundle produced by the state decode.
    typedef struct packed {
        logic iso;
        logic small_on;
        logic bulk_on;
        logic ready;
    } pgs_drive_t;

endpackage

// File: rtl/pgs_ack_sync.sv
module pgs_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic synced
);

    logic [STAGES-1:0] pipe_q;

    // One flop per stage; a chain return is asynchronous to clk.
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= 1'b0;
                else        pipe_q[s] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[s] <= 1'b0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign synced = pipe_q[STAGES-1];

endmodule

// File: rtl/pgs_wait_timer.sv
module pgs_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             done,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;

    // Counts cycles spent waiting; saturates at limit and flags expiry.
    // An arriving return (done) wins over expiry in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (!active || done) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (cnt_q == limit) begin
            exp_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = exp_q;

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
    import pgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       small_ret_s,
    input  logic       bulk_ret_s,
    output pgs_drive_t drive,
    output logic       wait_active,
    output logic       wait_done
);

    pgs_state_e state_q;
    pgs_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PGS_ASLEEP;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PGS_ASLEEP: begin
                // A stale return must drain before a new wake may start.
                if (!sleep_req && !small_ret_s && !bulk_ret_s)
                    state_d = PGS_WAKE_SMALL;
            end
            PGS_WAKE_SMALL: begin
                if (small_ret_s) state_d = PGS_WAKE_BULK;
            end
            PGS_WAKE_BULK: begin
                if (bulk_ret_s) state_d = PGS_READY;
            end
            PGS_READY: begin
                if (sleep_req) state_d = PGS_CLAMP;
            end
            PGS_CLAMP: begin
                state_d = PGS_ASLEEP;
            end
            default: state_d = PGS_ASLEEP;
        endcase
    end

    // Outputs, decoded from the state register only.
    always_comb begin
        drive       = '{iso: 1'b1, small_on: 1'b0, bulk_on: 1'b0, ready: 1'b0};
        wait_active = 1'b0;
        wait_done   = 1'b0;
        unique case (state_q)
            PGS_ASLEEP: begin
            end
            PGS_WAKE_SMALL: begin
                drive.small_on = 1'b1;
                wait_active    = 1'b1;
                wait_done      = small_ret_s;
            end
            PGS_WAKE_BULK: begin
                drive.small_on = 1'b1;
                drive.bulk_on  = 1'b1;
                wait_active    = 1'b1;
                wait_done      = bulk_ret_s;
            end
            PGS_READY: begin
                drive.iso      = 1'b0;
                drive.small_on = 1'b1;
                drive.bulk_on  = 1'b1;
                drive.ready    = 1'b1;
            end
            PGS_CLAMP: begin
                drive.small_on = 1'b1;
                drive.bulk_on  = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
    import pgs_pkg::*;
#(
    parameter int TMO_W    = 8,
    parameter int ACK_SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             small_ret,
    input  logic             bulk_ret,
    output logic             iso_en,
    output logic             small_en,
    output logic             bulk_en,
    output logic             dom_ready,
    output logic             ret_timeout
);

    localparam int NUM_GRP = 2;

    logic [NUM_GRP-1:0] ret_raw;
    logic [NUM_GRP-1:0] ret_s;
    pgs_drive_t         drive;
    logic               wait_active;
    logic               wait_done;

    assign ret_raw = {bulk_ret, small_ret};

    // One resynchronizer per switch group chain return.
    genvar g;
    for (g = 0; g < NUM_GRP; g++) begin : g_ret
        pgs_ack_sync #(.STAGES(ACK_SYNC)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (ret_raw[g]),
            .synced (ret_s[g])
        );
    end

    pgs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .small_ret_s (ret_s[0]),
        .bulk_ret_s  (ret_s[1]),
        .drive       (drive),
        .wait_active (wait_active),
        .wait_done   (wait_done)
    );

    pgs_wait_timer #(.CNT_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wait_active),
        .done    (wait_done),
        .limit   (tmo_limit),
        .expired (ret_timeout)
    );

    assign iso_en    = drive.iso;
    assign small_en  = drive.small_on;
    assign bulk_en   = drive.bulk_on;
    assign dom_ready = drive.ready;

endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic iso_en,
    input logic small_en,
    input logic bulk_en,
    input logic dom_ready,
    input logic ret_timeout
);

    AST_SMALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(small_en) |-> iso_en && !bulk_en && !dom_ready); // R2

    AST_BULK_AFTER_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bulk_en) |-> $past(small_en) && iso_en); // R4

    AST_RELEASE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_en |-> small_en && bulk_en && dom_ready); // R5

    AST_CLAMP_BEFORE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(small_en) |-> $past(iso_en) && !bulk_en); // R6

    AST_ISO_RISE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_en) |-> small_en && bulk_en); // R6

    AST_SLEEP_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dom_ready && sleep_req |=> iso_en && !dom_ready && small_en && bulk_en); // R6

    AST_ERR_ONLY_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
        ret_timeout |-> iso_en && small_en && !dom_ready); // R9

    AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_timeout && $past(ret_timeout) |-> $stable(small_en) && $stable(bulk_en)); // R9

    AST_ASLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !small_en && sleep_req |=> !small_en && !bulk_en); // R11

endmodule

bind pwr_gate_seq pgs_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .iso_en      (iso_en),
    .small_en    (small_en),
    .bulk_en     (bulk_en),
    .dom_ready   (dom_ready),
    .ret_timeout (ret_timeout)
);

// File: tb/pwr_gate_seq_tb_top.sv
module pwr_gate_seq_tb_top;

    localparam int TW   = 4;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep_req;
    logic [TW-1:0] tmo_limit;
    logic          small_ret;
    logic          bulk_ret;
    logic          iso_en;
    logic          small_en;
    logic          bulk_en;
    logic          dom_ready;
    logic          ret_timeout;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_gate_seq #(.TMO_W(TW), .ACK_SYNC(SYNC)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .tmo_limit   (tmo_limit),
        .small_ret   (small_ret),
        .bulk_ret    (bulk_ret),
        .iso_en      (iso_en),
        .small_en    (small_en),
        .bulk_en     (bulk_en),
        .dom_ready   (dom_ready),
        .ret_timeout (ret_timeout)
    );

    // Expected vector order: {iso, small, bulk, ready, err}
    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {iso_en, small_en, bulk_en, dom_ready, ret_timeout};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {iso,small,bulk,ready,err} = %b, expected %b", req, act, exp);
        end
    endtask

    // Called at the first negedge where the group's enable is visible.
    // Return is driven at index d; the group advances at index d+1+SYNC.
    task automatic wait_group(input int t, input int d, input bit is_bulk, input bit hs);
        for (int j = 0; j <= d + SYNC; j++) begin
            string lbl;
            bit    err_exp;
            err_exp = (j >= t + 1);
            if (err_exp)                lbl = "R9";
            else if (is_bulk && j == 0) lbl = "R4 R10";
            else if (is_bulk)           lbl = "R4";
            else                        lbl = "R2";
            chk(lbl, {1'b1, 1'b1, is_bulk, 1'b0, err_exp});
            if (hs && j == 0) sleep_req = 1'b1;   // R7: sleep mid-wake
            if (j == d) begin
                if (is_bulk) bulk_ret = 1'b1;
                else         small_ret = 1'b1;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n     = 1'b0;
        sleep_req = 1'b1;
        tmo_limit = '0;
        small_ret = 1'b0;
        bulk_ret  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 5'b10000);

        for (int t = 0; t < 4; t++) begin
            for (int da = 0; da < 5; da++) begin
                for (int db = 0; db < 5; db++) begin
                    for (int hs = 0; hs < 2; hs++) begin
                        chk("R11", 5'b10000);
                        tmo_limit = TW'(t);
                        sleep_req = 1'b0;
                        @(negedge clk);
                        wait_group(t, da, 1'b0, hs[0]);
                        wait_group(t, db, 1'b1, 1'b0);
                        chk("R5", 5'b01110);
                        if (hs != 0) begin
                            @(negedge clk);
                            chk("R7", 5'b11100);
                            @(negedge clk);
                            chk("R6", 5'b10000);
                        end else begin
                            repeat (2) begin
                                @(negedge clk);
                                chk("R5", 5'b01110);
                            end
                            sleep_req = 1'b1;
                            @(negedge clk);
                            chk("R6", 5'b11100);
                            sleep_req = 1'b0;   // R8: wake request during clamp
                            @(negedge clk);
                            chk("R8", 5'b10000);
                            repeat (2) begin
                                @(negedge clk);
                                chk("R3", 5'b10000);  // returns still high
                            end
                        end
                        sleep_req = 1'b1;
                        small_ret = 1'b0;
                        bulk_ret  = 1'b0;
                        repeat (SYNC + 2) begin
                            @(negedge clk);
                            chk("R11", 5'b10000);
                        end
                    end
                end
            end
        end

        // R3: stale small return blocks the wake until it drains.
        tmo_limit = '1;
        small_ret = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        sleep_req = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R3", 5'b10000);
        end
        small_ret = 1'b0;
        for (int k = 1; k <= SYNC; k++) begin
            @(negedge clk);
            chk("R3", 5'b10000);
        end
        @(negedge clk);
        chk("R3", 5'b11000);
        // R7: sleep raised with both returns arriving together.
        sleep_req = 1'b1;
        small_ret = 1'b1;
        bulk_ret  = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        chk("R4", 5'b11100);
        @(negedge clk);
        chk("R7", 5'b01110);
        @(negedge clk);
        chk("R7", 5'b11100);
        @(negedge clk);
        chk("R6", 5'b10000);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1: watchdog expired, actual running, expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule